// File: doc/BRIEF.md
# Dual-Channel Wiper Setting Store

This block keeps the tap setting for two independent digitally controlled resistor channels. It sits behind a serial command decoder. Each decoded command arrives as a one-cycle strobe. The strobe carries a channel index, a shutdown flag, a fuse-burn request, an override flag and, optionally, a data byte. For every channel the block holds a volatile setting, an emulated one-time fuse word with its status, and the shutdown and override state.

For each channel the block drives the code that is currently applied, a shutdown flag and a two-bit programming status. When a channel is unfused, the applied code is its volatile setting. Once the fuse is burned, the fused word is applied unless an override is active. While an override is active, the override data is applied. Shutdown is only reported as a flag: it never disturbs the stored setting.

Two reset inputs exist. `rst_ni` models power-on and clears the volatile state. `fuse_rst_ni` clears the fuse emulation only; it exists for bring-up, and `rst_ni` leaves the fuses untouched.

Top module: `wiper_setting_bank`

## Requirements
- R1: After `rst_ni` with blank fuses, every channel applies midscale code 0x80, shutdown is low, status is 00 and the selected channel is 0.
- R2: A strobe with data to an unfused channel makes that data its applied code from the next cycle.
- R3: The shutdown flag of the addressed channel takes the strobe's shutdown bit from the next cycle, and the applied code is unchanged by this.
- R4: Data written while a channel is shut down is stored. After shutdown is released, the channel applies the latest data written.
- R5: A data strobe with the burn bit to a blank channel fuses that strobe's data byte and sets the status {E1,E0}, bits [2c+1:2c] of `vbits_o`, to 11.
- R6: On a fused channel, a data strobe with the override bit low leaves the applied code at the fused word.
- R7: On a fused channel, a data strobe with the override bit high applies its data. A later data strobe with the override bit low returns the channel to the fused word.
- R8: `rst_ni` clears override and shutdown but keeps fuses. A fused channel then applies its fused word, and its status is kept.
- R9: A burn request on an already fused channel sets the status to 10 and leaves the fused word unchanged.
- R10: A strobe without data changes only the channel select and shutdown. Its burn and override bits have no effect.
- R11: Every strobe sets `sel_ch_o` to its channel. Strobes to one channel never change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async power-on reset of volatile state |
| fuse_rst_ni | input | 1 | Active-low async clear of the fuse emulation |
| wr_valid_i | input | 1 | Command strobe |
| wr_has_data_i | input | 1 | Strobe carries a data byte |
| wr_ch_i | input | 1 | Channel index |
| wr_shdn_i | input | 1 | Shutdown bit |
| wr_burn_i | input | 1 | Fuse-burn request |
| wr_ovr_i | input | 1 | Override bit |
| wr_data_i | input | 8 | Data byte |
| code_o | output | 16 | Applied code per channel, channel c at [8c+7:8c] |
| shdn_o | output | 2 | Shutdown flag per channel |
| vbits_o | output | 4 | Programming status {E1,E0} per channel |
| sel_ch_o | output | 1 | Last addressed channel |

## Verification
The bench builds the block with its defaults: two channels and an 8-bit code. With these values both channels can be observed side by side, so cross-channel leakage shows up. The same values also make the midscale code 0x80 and single-byte data values directly checkable. Fuse emulation is cleared only once, at the start. Every later power-on cycle therefore exercises fuse retention together with override loss.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    OTP_BLANK = 2'b00,
    OTP_FAIL  = 2'b10,
    OTP_OK    = 2'b11
  } otp_state_e;
endpackage

// File: rtl/wiper_fuse_cell.sv
module wiper_fuse_cell
  import wiper_pkg::*;
#(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              fuse_rst_ni,
  input  logic              burn_i,
  input  logic [CODE_W-1:0] value_i,
  output logic              fused_o,
  output logic [CODE_W-1:0] fuse_val_o,
  output logic [1:0]        vbits_o
);
  otp_state_e        state_q;
  logic [CODE_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge fuse_rst_ni) begin
    if (!fuse_rst_ni) begin
      state_q <= OTP_BLANK;
      val_q   <= '0;
    end else if (burn_i) begin
      if (state_q == OTP_BLANK) begin
        state_q <= OTP_OK;
        val_q   <= value_i;
      end else begin
        state_q <= OTP_FAIL;
      end
    end
  end

  assign fused_o    = (state_q != OTP_BLANK);
  assign fuse_val_o = val_q;
  assign vbits_o    = state_q;

  p_fuse_sticky_r9: assert property (@(posedge clk_i) disable iff (!fuse_rst_ni)
    fused_o |=> fused_o && (fuse_val_o == $past(fuse_val_o)));
  p_status_legal_r5: assert property (@(posedge clk_i) disable iff (!fuse_rst_ni)
    vbits_o != 2'b01);
endmodule

// File: rtl/wiper_channel.sv
module wiper_channel #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fuse_rst_ni,
  input  logic              hit_i,
  input  logic              has_data_i,
  input  logic              shdn_i,
  input  logic              burn_i,
  input  logic              ovr_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              shdn_o,
  output logic [1:0]        vbits_o
);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] set_q, fuse_val;
  logic              shdn_q, ovr_q, fused;
  logic              data_hit, set_we;

  assign data_hit = hit_i && has_data_i;
  // fused channel takes new data only under override
  assign set_we   = data_hit && (!fused || ovr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q  <= MID_CODE;
      shdn_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (hit_i)    shdn_q <= shdn_i;
      if (data_hit) ovr_q  <= ovr_i;
      if (set_we)   set_q  <= data_i;
    end
  end

  wiper_fuse_cell #(.CODE_W(CODE_W)) u_fuse (
    .clk_i      (clk_i),
    .fuse_rst_ni(fuse_rst_ni),
    .burn_i     (data_hit && burn_i),
    .value_i    (data_i),
    .fused_o    (fused),
    .fuse_val_o (fuse_val),
    .vbits_o    (vbits_o)
  );

  assign code_o = (fused && !ovr_q) ? fuse_val : set_q;
  assign shdn_o = shdn_q;

  p_instr_only_keeps_code_r10: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !fuse_rst_ni)
    (hit_i && !has_data_i) |=> $stable(code_o));
  p_idle_keeps_code_r3: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !fuse_rst_ni)
    !hit_i |=> $stable(code_o) && $stable(shdn_o));
  p_locked_write_r6: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !fuse_rst_ni)
    (fused && data_hit && !ovr_i) |=> (code_o == $past(fuse_val)));
  p_override_applies_r7: assert property (@(posedge clk_i)
    disable iff (!rst_ni || !fuse_rst_ni)
    (data_hit && ovr_i) |=> (code_o == $past(data_i)));
endmodule

// File: rtl/wiper_setting_bank.sv
module wiper_setting_bank #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     fuse_rst_ni,
  input  logic                     wr_valid_i,
  input  logic                     wr_has_data_i,
  input  logic [CH_W-1:0]          wr_ch_i,
  input  logic                     wr_shdn_i,
  input  logic                     wr_burn_i,
  input  logic                     wr_ovr_i,
  input  logic [CODE_W-1:0]        wr_data_i,
  output logic [NUM_CH*CODE_W-1:0] code_o,
  output logic [NUM_CH-1:0]        shdn_o,
  output logic [2*NUM_CH-1:0]      vbits_o,
  output logic [CH_W-1:0]          sel_ch_o
);
  logic [CH_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sel_q <= '0;
    else if (wr_valid_i) sel_q <= wr_ch_i;
  end
  assign sel_ch_o = sel_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    wiper_channel #(.CODE_W(CODE_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fuse_rst_ni(fuse_rst_ni),
      .hit_i      (wr_valid_i && (wr_ch_i == CH_W'(c))),
      .has_data_i (wr_has_data_i),
      .shdn_i     (wr_shdn_i),
      .burn_i     (wr_burn_i),
      .ovr_i      (wr_ovr_i),
      .data_i     (wr_data_i),
      .code_o     (code_o[c*CODE_W +: CODE_W]),
      .shdn_o     (shdn_o[c]),
      .vbits_o    (vbits_o[2*c +: 2])
    );
  end

  p_sel_follows_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> (sel_ch_o == $past(wr_ch_i)));
endmodule

// File: tb/tb_wiper_setting_bank.sv
module tb_wiper_setting_bank;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0, fuse_rst_ni = 1'b0;
  logic       wr_valid_i = 0, wr_has_data_i = 0, wr_ch_i = 0;
  logic       wr_shdn_i = 0, wr_burn_i = 0, wr_ovr_i = 0;
  logic [7:0] wr_data_i = 0;
  logic [15:0] code_o;
  logic [1:0]  shdn_o;
  logic [3:0]  vbits_o;
  logic        sel_ch_o;
  int n_chk = 0, n_err = 0;

  always #2.5 clk_i = ~clk_i;

  wiper_setting_bank dut (.*);

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int code_of(int ch); return code_o[ch*8 +: 8]; endfunction
  function automatic int st_of(int ch);   return vbits_o[ch*2 +: 2]; endfunction

  task automatic cmd(bit ch, bit dat, bit sd, bit burn, bit ovr, logic [7:0] d);
    @(negedge clk_i);
    wr_valid_i = 1; wr_has_data_i = dat; wr_ch_i = ch;
    wr_shdn_i = sd; wr_burn_i = burn; wr_ovr_i = ovr; wr_data_i = d;
    @(negedge clk_i);
    wr_valid_i = 0; wr_has_data_i = 0; wr_burn_i = 0; wr_ovr_i = 0;
  endtask

  task automatic por();
    @(negedge clk_i); rst_ni = 0;
    @(negedge clk_i); rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    for (int c = 0; c < 2; c++) begin
      chk("R1 code", code_of(c), 'h80);
      chk("R1 shdn", shdn_o[c], 0);
      chk("R1 status", st_of(c), 0);
    end
    chk("R1 sel", sel_ch_o, 0);
  endtask

  task automatic t_write_unfused();
    cmd(0, 1, 0, 0, 0, 8'h3C);
    chk("R2 ch0 code", code_of(0), 'h3C);
    chk("R11 ch1 untouched", code_of(1), 'h80);
    cmd(1, 1, 0, 0, 0, 8'hF1);
    chk("R2 ch1 code", code_of(1), 'hF1);
    chk("R11 sel", sel_ch_o, 1);
    chk("R11 ch0 untouched", code_of(0), 'h3C);
  endtask

  task automatic t_shutdown();
    cmd(0, 0, 1, 0, 0, 8'h00);
    chk("R3 shdn set", shdn_o[0], 1);
    chk("R3 code kept", code_of(0), 'h3C);
    chk("R11 ch1 shdn", shdn_o[1], 0);
    cmd(0, 1, 1, 0, 0, 8'h11);
    cmd(0, 1, 1, 0, 0, 8'h22);
    chk("R4 still shut", shdn_o[0], 1);
    cmd(0, 0, 0, 0, 0, 8'h00);
    chk("R4 released", shdn_o[0], 0);
    chk("R4 latest applied", code_of(0), 'h22);
  endtask

  task automatic t_instr_only();
    cmd(1, 0, 0, 1, 1, 8'h55);
    chk("R10 no burn", st_of(1), 0);
    chk("R10 code kept", code_of(1), 'hF1);
    chk("R10 sel", sel_ch_o, 1);
  endtask

  task automatic t_fuse();
    cmd(1, 1, 0, 1, 0, 8'hA7);
    chk("R5 status", st_of(1), 3);
    chk("R5 code", code_of(1), 'hA7);
    cmd(1, 1, 0, 0, 0, 8'h09);
    chk("R6 locked", code_of(1), 'hA7);
    cmd(1, 1, 0, 0, 1, 8'h5E);
    chk("R7 override", code_of(1), 'h5E);
    cmd(1, 0, 0, 0, 0, 8'h00);
    chk("R10 override held", code_of(1), 'h5E);
    cmd(1, 1, 0, 0, 0, 8'h01);
    chk("R7 revert", code_of(1), 'hA7);
    cmd(1, 1, 0, 0, 1, 8'h66);
    chk("R7 override again", code_of(1), 'h66);
  endtask

  task automatic t_power_cycle();
    por();
    chk("R8 fused code", code_of(1), 'hA7);
    chk("R8 status kept", st_of(1), 3);
    chk("R8 unfused mid", code_of(0), 'h80);
    chk("R8 shdn clear", shdn_o, 0);
  endtask

  task automatic t_reburn();
    cmd(1, 1, 0, 1, 0, 8'h12);
    chk("R9 status", st_of(1), 2);
    chk("R9 value kept", code_of(1), 'hA7);
    chk("R11 ch0 status", st_of(0), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk_i);
        fuse_rst_ni = 1; rst_ni = 1;
        @(negedge clk_i);
        t_reset();
        t_write_unfused();
        t_shutdown();
        t_instr_only();
        t_fuse();
        t_power_cycle();
        t_reburn();
      end
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule